// File: doc/BRIEF.md
# Dual-Mask Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines and presents them to a processor as two active-high outputs: a normal interrupt and a fast interrupt. Each output has its own enable mask. Software never writes a mask directly. It writes a set word that ORs ones into the mask, or a clear word that removes them, so separate agents can change different bits without a read-modify-write race.

Line 0 can also be raised by software. A latch is set and cleared through its own pair of write words, and it is ORed with external line 0. For each output, a register read returns the raw line state, the masked state and the mask itself. The block has no priority or vector logic. To cascade controllers, wire the normal output of one controller to an input line of another.

Top module: `dual_mask_intc`

## Requirements
- R1: `irqOut` is registered and, one clock after a change in the lines or the normal mask, equals the OR of (level AND normal mask).
- R2: `fiqOut` is registered and, one clock after a change in the lines or the fast mask, equals the OR of (level AND fast mask).
- R3: While reset is held, and after it is released, both masks and the software latch are zero. Both outputs are low and the mask reads return zero.
- R4: A write to word 2 ORs the data into the normal mask. A write to word 3 clears the mask bits where the data is 1. A read of word 2 returns the normal mask.
- R5: A write to word 10 ORs the data into the fast mask. A write to word 11 clears the mask bits where the data is 1. A read of word 10 returns the fast mask.
- R6: A write to word 4 with data bit 0 = 1 sets the software latch, and a write to word 5 with bit 0 = 1 clears it. Writes with bit 0 = 0 change nothing. Level bit 0 is external line 0 OR the latch.
- R7: A read of word 4 returns level bit 0 in bit 0, with bits 31..1 zero.
- R8: A read of word 0 returns level AND normal mask, and a read of word 8 returns level AND fast mask. Reads of words 1 and 9 return the raw level.
- R9: Writes to the read-only words 0, 1, 8 and 9, and to unassigned words, change no state. Reads of the write-only words 3, 5 and 11, and of unassigned words, return zero.
- R10: Level bits 31..1 follow the input lines in the same cycle, with no latching. A line that drops is gone from the raw read at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | 32 | Level-sensitive interrupt request lines |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, zero when there is no read |
| irqOut | output | 1 | Normal interrupt output, active high |
| fiqOut | output | 1 | Fast interrupt output, active high |

## Verification
The masking function is driven with line patterns that hit enabled bits, patterns that hit only disabled bits, and patterns that hit a bit enabled for one output only. These separate an AND from an OR of mask and level, and they catch any swap between the two masks. Mask updates are applied in several steps: two sets on disjoint bits, then a clear on a subset. A set that overwrote the mask instead of ORing into it would fail, and so would a clear that used inverted polarity. Bit 0 is exercised from the latch alone, from the external line alone, and with data whose bit 0 is clear. This shows the OR merge and the bit-0 qualification of the latch writes.

// File: rtl/dual_mask_intc_pkg.sv
package dual_mask_intc_pkg;

  // Word indexes; software depends on these values.
  localparam int unsigned IdxIrqStat  = 0;
  localparam int unsigned IdxIrqRaw   = 1;
  localparam int unsigned IdxIrqEnSet = 2;
  localparam int unsigned IdxIrqEnClr = 3;
  localparam int unsigned IdxSoftSet  = 4;
  localparam int unsigned IdxSoftClr  = 5;
  localparam int unsigned IdxFiqStat  = 8;
  localparam int unsigned IdxFiqRaw   = 9;
  localparam int unsigned IdxFiqEnSet = 10;
  localparam int unsigned IdxFiqEnClr = 11;

  typedef struct packed {
    logic irqEnSet;
    logic irqEnClr;
    logic fiqEnSet;
    logic fiqEnClr;
    logic softSet;
    logic softClr;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_IRQ_STAT,
    RD_RAW,
    RD_IRQ_EN,
    RD_SOFT,
    RD_FIQ_STAT,
    RD_FIQ_EN
  } readSel_t;

endpackage

// File: rtl/dual_mask_intc_ctrl.sv
module dual_mask_intc_ctrl
  import dual_mask_intc_pkg::*;
#(
  parameter int unsigned AddrW = 6
) (
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [AddrW-1:0] busAddr,
  input  logic             wdataBit0,
  output ctrlStrobes_t     strobes,
  output readSel_t         readSel
);

  logic doWrite;
  logic doRead;

  assign doWrite = busSel && busWrite;
  assign doRead  = busSel && !busWrite;

  always_comb begin
    strobes = '0;
    if (doWrite) begin
      unique case (busAddr)
        AddrW'(IdxIrqEnSet): strobes.irqEnSet = 1'b1;
        AddrW'(IdxIrqEnClr): strobes.irqEnClr = 1'b1;
        AddrW'(IdxFiqEnSet): strobes.fiqEnSet = 1'b1;
        AddrW'(IdxFiqEnClr): strobes.fiqEnClr = 1'b1;
        AddrW'(IdxSoftSet):  strobes.softSet  = wdataBit0;
        AddrW'(IdxSoftClr):  strobes.softClr  = wdataBit0;
        default: ;
      endcase
    end
  end

  always_comb begin
    readSel = RD_NONE;
    if (doRead) begin
      unique case (busAddr)
        AddrW'(IdxIrqStat):  readSel = RD_IRQ_STAT;
        AddrW'(IdxIrqRaw):   readSel = RD_RAW;
        AddrW'(IdxIrqEnSet): readSel = RD_IRQ_EN;
        AddrW'(IdxSoftSet):  readSel = RD_SOFT;
        AddrW'(IdxFiqStat):  readSel = RD_FIQ_STAT;
        AddrW'(IdxFiqRaw):   readSel = RD_RAW;
        AddrW'(IdxFiqEnSet): readSel = RD_FIQ_EN;
        default:             readSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dual_mask_intc_datapath.sv
module dual_mask_intc_datapath
  import dual_mask_intc_pkg::*;
#(
  parameter int unsigned NumLines = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumLines-1:0] irqLines,
  input  logic [NumLines-1:0] busWdata,
  input  ctrlStrobes_t        strobes,
  input  readSel_t            readSel,
  output logic [NumLines-1:0] busRdata,
  output logic                irqOut,
  output logic                fiqOut,
  output logic [NumLines-1:0] irqEn,
  output logic [NumLines-1:0] fiqEn,
  output logic                swLatch,
  output logic [NumLines-1:0] rawLevel
);

  // Line 0 merges the software latch; the others pass straight through.
  for (genvar i = 0; i < NumLines; i++) begin : g_level
    if (i == 0) begin : g_soft
      assign rawLevel[i] = irqLines[i] | swLatch;
    end else begin : g_plain
      assign rawLevel[i] = irqLines[i];
    end
  end

  logic [NumLines-1:0] irqMasked;
  logic [NumLines-1:0] fiqMasked;

  assign irqMasked = rawLevel & irqEn;
  assign fiqMasked = rawLevel & fiqEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn <= '0;
    end else if (strobes.irqEnSet) begin
      irqEn <= irqEn | busWdata;
    end else if (strobes.irqEnClr) begin
      irqEn <= irqEn & ~busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fiqEn <= '0;
    end else if (strobes.fiqEnSet) begin
      fiqEn <= fiqEn | busWdata;
    end else if (strobes.fiqEnClr) begin
      fiqEn <= fiqEn & ~busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swLatch <= 1'b0;
    end else if (strobes.softSet) begin
      swLatch <= 1'b1;
    end else if (strobes.softClr) begin
      swLatch <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      irqOut <= |irqMasked;
      fiqOut <= |fiqMasked;
    end
  end

  always_comb begin
    unique case (readSel)
      RD_IRQ_STAT: busRdata = irqMasked;
      RD_RAW:      busRdata = rawLevel;
      RD_IRQ_EN:   busRdata = irqEn;
      RD_SOFT:     busRdata = {{(NumLines-1){1'b0}}, rawLevel[0]};
      RD_FIQ_STAT: busRdata = fiqMasked;
      RD_FIQ_EN:   busRdata = fiqEn;
      default:     busRdata = '0;
    endcase
  end

endmodule

// File: rtl/dual_mask_intc.sv
module dual_mask_intc
  import dual_mask_intc_pkg::*;
#(
  parameter int unsigned NumLines = 32,
  parameter int unsigned AddrW    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NumLines-1:0] irqLines,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [AddrW-1:0]    busAddr,
  input  logic [NumLines-1:0] busWdata,
  output logic [NumLines-1:0] busRdata,
  output logic                irqOut,
  output logic                fiqOut
);

  ctrlStrobes_t        strobes;
  readSel_t            readSel;
  logic [NumLines-1:0] irqEn;
  logic [NumLines-1:0] fiqEn;
  logic                swLatch;
  logic [NumLines-1:0] rawLevel;

  dual_mask_intc_ctrl #(.AddrW(AddrW)) u_ctrl (
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .wdataBit0 (busWdata[0]),
    .strobes   (strobes),
    .readSel   (readSel)
  );

  dual_mask_intc_datapath #(.NumLines(NumLines)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .irqLines (irqLines),
    .busWdata (busWdata),
    .strobes  (strobes),
    .readSel  (readSel),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut),
    .irqEn    (irqEn),
    .fiqEn    (fiqEn),
    .swLatch  (swLatch),
    .rawLevel (rawLevel)
  );

endmodule

// File: rtl/dual_mask_intc_chk.sv
module dual_mask_intc_chk #(
  parameter int unsigned NumLines = 32,
  parameter int unsigned AddrW    = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWrite,
  input logic [AddrW-1:0]    busAddr,
  input logic [NumLines-1:0] busWdata,
  input logic [NumLines-1:0] busRdata,
  input logic                irqOut,
  input logic                fiqOut,
  input logic [NumLines-1:0] irqEn,
  input logic [NumLines-1:0] fiqEn,
  input logic                swLatch,
  input logic [NumLines-1:0] rawLevel
);

  logic wrAcc;
  logic rdAcc;
  assign wrAcc = busSel && busWrite;
  assign rdAcc = busSel && !busWrite;

  // R1
  a_r1_irq_output: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == $past(|(rawLevel & irqEn)));

  // R2
  a_r2_fiq_output: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> fiqOut == $past(|(rawLevel & fiqEn)));

  // R3
  a_r3_reset_clean: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irqOut && !fiqOut && irqEn == '0 && fiqEn == '0 && !swLatch));

  // R4
  a_r4_irq_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && busAddr == AddrW'(2)) |=> irqEn == ($past(irqEn) | $past(busWdata)));

  a_r4_irq_clr: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && busAddr == AddrW'(3)) |=> irqEn == ($past(irqEn) & ~$past(busWdata)));

  // R5
  a_r5_fiq_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && busAddr == AddrW'(10)) |=> fiqEn == ($past(fiqEn) | $past(busWdata)));

  a_r5_fiq_clr: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && busAddr == AddrW'(11)) |=> fiqEn == ($past(fiqEn) & ~$past(busWdata)));

  // R6
  a_r6_soft_bit0: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && (busAddr == AddrW'(4) || busAddr == AddrW'(5)) && !busWdata[0])
      |=> $stable(swLatch));

  // R9
  a_r9_ro_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && (busAddr == AddrW'(0) || busAddr == AddrW'(1) ||
               busAddr == AddrW'(8) || busAddr == AddrW'(9) || busAddr > AddrW'(11)))
      |=> ($stable(irqEn) && $stable(fiqEn) && $stable(swLatch)));

  a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && (busAddr == AddrW'(3) || busAddr == AddrW'(5) || busAddr == AddrW'(11)))
      |-> busRdata == '0);

endmodule

bind dual_mask_intc dual_mask_intc_chk #(.NumLines(NumLines), .AddrW(AddrW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .irqOut   (irqOut),
  .fiqOut   (fiqOut),
  .irqEn    (irqEn),
  .fiqEn    (fiqEn),
  .swLatch  (swLatch),
  .rawLevel (rawLevel)
);

// File: tb/dual_mask_intc_bench.sv
`timescale 1ns/1ps
module dual_mask_intc_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqLines = '0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic        fiqOut;

  int checkCount = 0;
  int failCount  = 0;

  always #2 clk = ~clk;

  dual_mask_intc u_dual_mask_intc (
    .clk      (clk),
    .rstN     (rstN),
    .irqLines (irqLines),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] val);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = 6'(idx); busWdata = val;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input int idx, output logic [31:0] val);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = 6'(idx);
    #1 val = busRdata;
    busSel = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic setLines(input logic [31:0] v);
    @(negedge clk);
    irqLines = v;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    chk("R3 irqOut after reset", 32'(irqOut), 0);
    chk("R3 fiqOut after reset", 32'(fiqOut), 0);
    rd(2, v);  chk("R3 normal mask", v, 0);
    rd(10, v); chk("R3 fast mask", v, 0);
    rd(4, v);  chk("R3 soft bit", v, 0);
  endtask

  task automatic test_irq_mask();
    logic [31:0] v;
    wr(2, 32'h0000_00F0);
    wr(2, 32'h0F00_0000);
    rd(2, v); chk("R4 set ORs", v, 32'h0F00_00F0);
    wr(3, 32'h0000_0030);
    rd(2, v); chk("R4 clear", v, 32'h0F00_00C0);
  endtask

  task automatic test_irq_out();
    logic [31:0] v;
    setLines(32'h0000_0040);
    chk("R1 not yet registered", 32'(irqOut), 0);
    settle();
    chk("R1 enabled line raises irq", 32'(irqOut), 1);
    chk("R2 fiq stays low", 32'(fiqOut), 0);
    rd(0, v); chk("R8 masked irq read", v, 32'h0000_0040);
    rd(1, v); chk("R8 raw read", v, 32'h0000_0040);
    setLines(32'h0000_0020);
    settle();
    chk("R1 disabled line no irq", 32'(irqOut), 0);
    rd(0, v); chk("R8 masked irq read zero", v, 0);
  endtask

  task automatic test_fiq();
    logic [31:0] v;
    wr(10, 32'h0000_0003);
    wr(11, 32'h0000_0001);
    rd(10, v); chk("R5 fast mask", v, 32'h0000_0002);
    setLines(32'h0000_0022);
    settle();
    chk("R2 fiq high", 32'(fiqOut), 1);
    chk("R1 irq low for fast-only bit", 32'(irqOut), 0);
    rd(8, v); chk("R8 masked fiq read", v, 32'h0000_0002);
    rd(9, v); chk("R8 raw read via word 9", v, 32'h0000_0022);
    setLines(32'h0);
    settle();
    chk("R2 fiq falls", 32'(fiqOut), 0);
  endtask

  task automatic test_soft();
    logic [31:0] v;
    wr(2, 32'h1);
    wr(4, 32'h2);
    rd(4, v); chk("R6 set without bit0 ignored", v, 0);
    settle();
    chk("R6 irq low without latch", 32'(irqOut), 0);
    wr(4, 32'h1);
    rd(1, v); chk("R6 latch in raw bit0", v, 1);
    rd(4, v); chk("R7 soft read", v, 1);
    chk("R6 irq from latch", 32'(irqOut), 1);
    wr(5, 32'h0);
    rd(4, v); chk("R6 clear without bit0 ignored", v, 1);
    wr(5, 32'h1);
    rd(4, v); chk("R6 clear latch", v, 0);
    settle();
    chk("R6 irq drops after clear", 32'(irqOut), 0);
  endtask

  task automatic test_soft_read();
    logic [31:0] v;
    setLines(32'hFFFF_FFFE);
    rd(4, v); chk("R7 upper bits hidden", v, 0);
    setLines(32'hFFFF_FFFF);
    rd(4, v); chk("R7 external line0 shown", v, 1);
    setLines(32'h0);
  endtask

  task automatic test_direction();
    logic [31:0] v;
    logic [31:0] irqBefore;
    logic [31:0] fiqBefore;
    rd(2, irqBefore);
    rd(10, fiqBefore);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(8, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    wr(40, 32'hFFFF_FFFF);
    rd(2, v);  chk("R9 normal mask unchanged", v, irqBefore);
    rd(10, v); chk("R9 fast mask unchanged", v, fiqBefore);
    rd(4, v);  chk("R9 latch unchanged", v, 0);
    setLines(32'hFFFF_FFFF);
    rd(3, v);  chk("R9 word 3 reads zero", v, 0);
    rd(5, v);  chk("R9 word 5 reads zero", v, 0);
    rd(11, v); chk("R9 word 11 reads zero", v, 0);
    rd(6, v);  chk("R9 unassigned reads zero", v, 0);
    setLines(32'h0);
  endtask

  task automatic test_follow();
    logic [31:0] v;
    setLines(32'h8000_0000);
    rd(1, v); chk("R10 raw follows rise", v, 32'h8000_0000);
    setLines(32'h0);
    rd(1, v); chk("R10 raw follows fall", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    settle();
    test_reset();
    test_irq_mask();
    test_irq_out();
    test_fiq();
    test_soft();
    test_soft_read();
    test_direction();
    test_follow();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule